// File: doc/BRIEF.md
# PCI Power State and Wake Event Controller

This block keeps the power-management state of one PCI device function and produces the power-management event (PME) request. The host writes one 16-bit control word. That word sets the 2-bit power-state field and the PME enable bit, and it can clear a sticky PME status bit. The block then gates the function's memory-space decode and its interrupt output according to the state it is in. While the function is in D3hot, the block watches four serial channels for wake activity. A wake event is a receive line held low (a start bit) or any raised modem-status delta flag.

The controller has four named states:
- **D0_UNINIT**: entered from reset and after the restore interval.
- **D0_ACTIVE**: entered from D0_UNINIT when the host raises `init_done`.
- **D3_HOT**: entered from either D0 state when the host writes power-state code 11.
- **RESTORE**: entered from D3_HOT when the host writes power-state code 00. The bus output drivers are held disabled for `DIS_CYCLES` clocks, after which the controller goes to D0_UNINIT.

The named transitions are: RESET→D0_UNINIT, D0_UNINIT→D0_ACTIVE (init), D0_*→D3_HOT (suspend), D3_HOT→RESTORE (resume), and RESTORE→D0_UNINIT (restore done).

Top module: `pwr_pme_ctrl`

## Requirements
- R1: After reset the state is D0_UNINIT. `reg_rdata` reads 0x0000, and `mem_en`, `irq_en`, `pme_drive_low` and `drv_disable` are all 0.
- R2: In D0_UNINIT, `init_done` high at a clock edge moves the block to D0_ACTIVE. From the next cycle on, `mem_en` and `irq_en` are 1.
- R3: A write whose bits [1:0] are 11, made in D0_UNINIT or D0_ACTIVE, enters D3_HOT. From the next cycle, `reg_rdata[1:0]` reads 11 and `mem_en` and `irq_en` are 0.
- R4: A write with bits [1:0] equal to 01 or 10 leaves the power state unchanged.
- R5: Register layout: power state at [1:0] (00 = D0, 11 = D3hot), PME enable at bit 8, PME status at bit 15. Bits [7:2] and [14:9] always read 0.
- R6: In D3_HOT, a low level on any bit of `rx_line` sets PME status at the next edge.
- R7: In D3_HOT, any set bit of `msr_delta` sets PME status at the next edge. There are four bits per channel, and channel c occupies bits [4c+3:4c].
- R8: PME status is set by a wake event whatever the enable bit holds. `pme_drive_low` is 1 exactly when status and enable are both 1.
- R9: Every write loads PME enable from bit 8. Writing 1 to bit 15 clears PME status, and writing 0 to bit 15 leaves it unchanged.
- R10: If a status-clearing write and a wake event in D3_HOT fall in the same cycle, the status reads 1 afterwards.
- R11: A write of power-state code 00 in D3_HOT raises `drv_disable` for exactly `DIS_CYCLES` cycles (default 16). During those cycles `reg_rdata[1:0]` reads 00, PME status and enable are kept, and `mem_en`/`irq_en` stay 0. The block then sits in D0_UNINIT.
- R12: Wake activity outside D3_HOT (including during RESTORE) does not set PME status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 16 | Control-word write data |
| init_done | input | 1 | Host finished initialization |
| rx_line | input | NCH | Receive line level per channel |
| msr_delta | input | 4*NCH | Modem-status delta flags, four per channel |
| reg_rdata | output | 16 | Control-word read value |
| pme_drive_low | output | 1 | Enable for pulling the active-low PME line low |
| mem_en | output | 1 | Memory-space decode enable |
| irq_en | output | 1 | Interrupt output enable |
| drv_disable | output | 1 | Bus output drivers held off during restore |

## Verification
The write-one-to-clear of PME status and a D3hot wake event can occur in the same clock. To provoke this, the bench holds a modem delta flag high while writing bit 15 set. The case is judged by the status bit reading 1 on the following cycle, with the PME request still asserted. A second overlap comes from status clears and wake inputs issued during the restore interval. The bench checks that the clear takes effect and that the wake input is ignored there.

// File: rtl/pwr_pme_pkg.sv
package pwr_pme_pkg;

    typedef enum logic [1:0] {
        PS_D0_UNINIT = 2'd0,
        PS_D0_ACTIVE = 2'd1,
        PS_D3_HOT    = 2'd2,
        PS_RESTORE   = 2'd3
    } pwr_state_e;

    localparam int          CTRL_W       = 16;
    localparam logic [1:0]  CODE_D0      = 2'b00;
    localparam logic [1:0]  CODE_D3HOT   = 2'b11;
    localparam int          BIT_PME_EN   = 8;
    localparam int          BIT_PME_STS  = 15;

endpackage

// File: rtl/pme_wake_detect.sv
module pme_wake_detect #(
    parameter int NCH    = 4,
    parameter int NDELTA = 4
) (
    input  logic [NCH-1:0]        rx_line,
    input  logic [NCH*NDELTA-1:0] msr_delta,
    output logic                  wake
);
    logic [NCH-1:0] ch_evt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_evt[c] = ~rx_line[c] | (|msr_delta[c*NDELTA +: NDELTA]);
    end

    assign wake = |ch_evt;
endmodule

// File: rtl/pme_state_fsm.sv
module pme_state_fsm
    import pwr_pme_pkg::*;
#(
    parameter int DIS_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wr_code,
    input  logic       init_done,
    output pwr_state_e state,
    output logic       mem_en,
    output logic       irq_en,
    output logic       drv_disable,
    output logic       in_d3
);
    localparam int CW = $clog2(DIS_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DIS_CYCLES - 1);

    pwr_state_e    state_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_D0_UNINIT: begin
                if (wr && wr_code == CODE_D3HOT) state_nx = PS_D3_HOT;
                else if (init_done)              state_nx = PS_D0_ACTIVE;
            end
            PS_D0_ACTIVE: begin
                if (wr && wr_code == CODE_D3HOT) state_nx = PS_D3_HOT;
            end
            PS_D3_HOT: begin
                if (wr && wr_code == CODE_D0)    state_nx = PS_RESTORE;
            end
            PS_RESTORE: begin
                if (cnt == CNT_LAST)             state_nx = PS_D0_UNINIT;
            end
            default:                             state_nx = PS_D0_UNINIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_D0_UNINIT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == PS_RESTORE) cnt <= cnt + 1'b1;
            else                     cnt <= '0;
        end
    end

    always_comb begin
        mem_en      = 1'b0;
        irq_en      = 1'b0;
        drv_disable = 1'b0;
        in_d3       = 1'b0;
        unique case (state)
            PS_D0_UNINIT: ;
            PS_D0_ACTIVE: begin
                mem_en = 1'b1;
                irq_en = 1'b1;
            end
            PS_D3_HOT:    in_d3 = 1'b1;
            PS_RESTORE:   drv_disable = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/pme_status_reg.sv
module pme_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_en_bit,
    input  logic wr_clr_bit,
    input  logic wake_set,
    output logic pme_en,
    output logic pme_sts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pme_en  <= 1'b0;
            pme_sts <= 1'b0;
        end else begin
            if (wr) pme_en <= wr_en_bit;
            if (wake_set)               pme_sts <= 1'b1;
            else if (wr && wr_clr_bit)  pme_sts <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_pme_ctrl.sv
module pwr_pme_ctrl
    import pwr_pme_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DIS_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [CTRL_W-1:0]    reg_wdata,
    input  logic                 init_done,
    input  logic [NCH-1:0]       rx_line,
    input  logic [4*NCH-1:0]     msr_delta,
    output logic [CTRL_W-1:0]    reg_rdata,
    output logic                 pme_drive_low,
    output logic                 mem_en,
    output logic                 irq_en,
    output logic                 drv_disable
);
    pwr_state_e state;
    logic       in_d3;
    logic       wake;
    logic       pme_en;
    logic       pme_sts;
    logic       unused_wdata;

    assign unused_wdata = ^{reg_wdata[14:9], reg_wdata[7:2]};

    pme_wake_detect #(.NCH(NCH), .NDELTA(4)) u_wake (
        .rx_line   (rx_line),
        .msr_delta (msr_delta),
        .wake      (wake)
    );

    pme_state_fsm #(.DIS_CYCLES(DIS_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .wr_code     (reg_wdata[1:0]),
        .init_done   (init_done),
        .state       (state),
        .mem_en      (mem_en),
        .irq_en      (irq_en),
        .drv_disable (drv_disable),
        .in_d3       (in_d3)
    );

    pme_status_reg u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .wr_en_bit  (reg_wdata[BIT_PME_EN]),
        .wr_clr_bit (reg_wdata[BIT_PME_STS]),
        .wake_set   (wake & in_d3),
        .pme_en     (pme_en),
        .pme_sts    (pme_sts)
    );

    assign pme_drive_low = pme_en & pme_sts;

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[1:0]         = (state == PS_D3_HOT) ? CODE_D3HOT : CODE_D0;
        reg_rdata[BIT_PME_EN]  = pme_en;
        reg_rdata[BIT_PME_STS] = pme_sts;
    end
endmodule

// File: rtl/pwr_pme_chk.sv
module pwr_pme_chk #(
    parameter int NCH        = 4,
    parameter int DIS_CYCLES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [15:0]      reg_wdata,
    input logic [NCH-1:0]   rx_line,
    input logic [4*NCH-1:0] msr_delta,
    input logic [15:0]      reg_rdata,
    input logic             pme_drive_low,
    input logic             mem_en,
    input logic             irq_en,
    input logic             drv_disable
);
    int  run_len;
    logic d3_wake;

    assign d3_wake = (reg_rdata[1:0] == 2'b11) && ((~&rx_line) || (|msr_delta));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_len <= 0;
        else if (drv_disable) run_len <= run_len + 1;
        else                  run_len <= 0;
    end

    AST_D3_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b11) |-> (!mem_en && !irq_en)); // R3
    AST_ODD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_wdata[1:0] == 2'b01 || reg_wdata[1:0] == 2'b10)) |=> $stable(reg_rdata[1:0])); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[14:9] == 6'd0) && (reg_rdata[7:2] == 6'd0)); // R5
    AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        d3_wake |=> reg_rdata[15]); // R6
    AST_PME_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        pme_drive_low |-> (reg_rdata[15] && reg_rdata[8])); // R8
    AST_STS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[15] && !d3_wake) |=> !reg_rdata[15]); // R9
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15] && !(reg_wr && reg_wdata[15])) |=> reg_rdata[15]); // R9
    AST_DRV_FROM_D3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_disable) |-> ($past(reg_rdata[1:0]) == 2'b11)); // R11
    AST_DRV_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        drv_disable |-> (!mem_en && !irq_en)); // R11
    AST_DRV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        drv_disable |-> (run_len < DIS_CYCLES)); // R11
    AST_NO_WAKE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[15] && reg_rdata[1:0] != 2'b11) |=> !reg_rdata[15]); // R12
endmodule

bind pwr_pme_ctrl pwr_pme_chk #(.NCH(NCH), .DIS_CYCLES(DIS_CYCLES)) chk_i (.*);

// File: tb/pwr_pme_ctrl_tb_top.sv
module pwr_pme_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int DIS = 16;

    typedef struct {
        logic [15:0] rd;
        logic        pme;
        logic        mem;
        logic        irq;
        logic        drv;
        string       req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [15:0]      reg_wdata = '0;
    logic             init_done = 1'b0;
    logic [NCH-1:0]   rx_line = '1;
    logic [4*NCH-1:0] msr_delta = '0;
    logic [15:0]      reg_rdata;
    logic             pme_drive_low, mem_en, irq_en, drv_disable;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    pwr_pme_ctrl #(.NCH(NCH), .DIS_CYCLES(DIS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .init_done(init_done), .rx_line(rx_line), .msr_delta(msr_delta),
        .reg_rdata(reg_rdata), .pme_drive_low(pme_drive_low), .mem_en(mem_en),
        .irq_en(irq_en), .drv_disable(drv_disable)
    );

    task automatic step(input logic wr, input logic [15:0] wd, input logic ini,
                        input logic [NCH-1:0] rx, input logic [4*NCH-1:0] dl,
                        input logic [15:0] e_rd, input logic e_pme, input logic e_mem,
                        input logic e_irq, input logic e_drv, input string req);
        exp_t e;
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; init_done = ini; rx_line = rx; msr_delta = dl;
        @(posedge clk);
        e.rd = e_rd; e.pme = e_pme; e.mem = e_mem; e.irq = e_irq; e.drv = e_drv; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: pops each expected item and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (reg_rdata !== e.rd || pme_drive_low !== e.pme || mem_en !== e.mem ||
                    irq_en !== e.irq || drv_disable !== e.drv) begin
                    n_fail++;
                    $display("FAIL %s: got rd=%h pme=%b mem=%b irq=%b drv=%b exp rd=%h pme=%b mem=%b irq=%b drv=%b",
                             e.req, reg_rdata, pme_drive_low, mem_en, irq_en, drv_disable,
                             e.rd, e.pme, e.mem, e.irq, e.drv);
                end
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        step(0, 16'h0000, 0, '1, '0, 16'h0000, 0, 0, 0, 0, "R1 reset state");
        rst_n = 1'b1;
        step(0, 16'h0000, 1, '1, '0, 16'h0000, 0, 1, 1, 0, "R2 init done to active");
        step(0, 16'h0000, 0, '1, '0, 16'h0000, 0, 1, 1, 0, "R2 active holds");
        step(0, 16'h0000, 0, 4'b1110, '0, 16'h0000, 0, 1, 1, 0, "R12 wake in D0 ignored");
        step(1, 16'h0001, 0, '1, '0, 16'h0000, 0, 1, 1, 0, "R4 code 01 ignored");
        step(1, 16'h0002, 0, '1, '0, 16'h0000, 0, 1, 1, 0, "R4 code 10 ignored");
        step(1, 16'hFEFF, 0, '1, '0, 16'h0003, 0, 0, 0, 0, "R3 R5 enter D3hot, reserved zero");
        step(0, 16'h0000, 0, 4'b1011, '0, 16'h8003, 0, 0, 0, 0, "R6 R8 rx low sets status, no pme");
        step(1, 16'h0103, 0, '1, '0, 16'h8103, 1, 0, 0, 0, "R9 R8 write 0 keeps status, enable");
        step(1, 16'h8103, 0, '1, '0, 16'h0103, 0, 0, 0, 0, "R9 write 1 clears status");
        step(0, 16'h0000, 0, '1, 16'h0020, 16'h8103, 1, 0, 0, 0, "R7 msr delta sets status");
        step(1, 16'h8103, 0, '1, 16'h0020, 16'h8103, 1, 0, 0, 0, "R10 set beats clear");
        step(1, 16'h0102, 0, '1, '0, 16'h8103, 1, 0, 0, 0, "R4 code 10 in D3hot ignored");
        step(1, 16'h0100, 0, '1, '0, 16'h8100, 1, 0, 0, 1, "R11 restore start, regs kept");
        step(1, 16'h8100, 0, '1, '0, 16'h0100, 0, 0, 0, 1, "R11 R9 clear during restore");
        for (int k = 2; k < DIS; k++)
            step(0, 16'h0000, 0, 4'b1110, 16'h1000, 16'h0100, 0, 0, 0, 1, "R11 R12 restore window");
        step(0, 16'h0000, 0, 4'b1110, '0, 16'h0100, 0, 0, 0, 0, "R11 restore ends in D0 uninit");
        step(0, 16'h0000, 1, '1, '0, 16'h0100, 0, 1, 1, 0, "R2 init after restore");
        step(1, 16'h0003, 0, '1, '0, 16'h0003, 0, 0, 0, 0, "R3 R9 D3hot again, enable cleared");
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule